// File: doc/BRIEF.md
# Line-Matched Replay Store Buffer

This block keeps a short, ordered record of speculative allocate-and-write stores that a data cache model has made, so that any one of them can later be written back to memory. Each record request carries an address, a 32-bit value and a flag saying whether the target is cacheable. Only cacheable stores are kept. They are appended at the tail of a fixed-depth array.

An invalidate request names an address. The buffer searches its entries from the oldest to the newest for the first one that lies in the same cache line. That entry is taken out of the array and issued as one write, with its own stored address and value, on a valid/ready memory write port. Entries behind it move up toward the head, and their order is kept. A discard command throws away every entry at once. While a write is waiting for its ready, the block takes no new command.

Top module: `line_replay_buf`

## Requirements
- R1: A record with `rec_cached` low leaves the buffer unchanged. A later invalidate of that line produces no write.
- R2: Cacheable records are appended in arrival order. Entries in the same line are replayed oldest first.
- R3: `full` is high when DEPTH entries are held. A record that arrives while the buffer is full is dropped. `overflow` is then high for exactly the one cycle that follows the dropped request.
- R4: Line matching compares the address bits above bit LINE_BITS-1 (bits 31:5 by default). Two addresses in the same 32-byte line match. Addresses in different lines do not.
- R5: An accepted invalidate that matches raises `wr_valid` in the next cycle. `wr_addr` and `wr_data` then carry the stored address and value of the oldest matching entry.
- R6: Only that one entry is removed. Later matching entries stay queued, and all remaining entries keep their relative order.
- R7: An invalidate with no match produces no write and leaves the buffer contents and fill level unchanged.
- R8: A discard empties the buffer: `empty` is high in the next cycle, and no old entry can be replayed after it.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady. Every command presented while `wr_valid` is high is ignored.
- R10: When commands arrive in the same cycle, discard wins over invalidate, and invalidate wins over record. The commands that lose are ignored.
- R11: After reset, `empty` is high, and `full`, `overflow` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | Record request |
| rec_addr | input | AW | Store address |
| rec_data | input | DW | Store value |
| rec_cached | input | 1 | Target is cacheable |
| inv_valid | input | 1 | Invalidate request |
| inv_addr | input | AW | Address whose line is searched |
| discard | input | 1 | Drop all entries |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entries held |
| overflow | output | 1 | Pulse: a record was dropped because the buffer was full |
| wr_valid | output | 1 | Memory write pending |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write value |
| wr_ready | input | 1 | Memory accepts the write |

## Verification
The assertions check several things on every cycle. A pending write must hold steady until it is accepted. An overflow can only follow a full buffer. A discard must leave the buffer empty. An uncached record must leave the fill level unchanged. Every accepted invalidate must end in one of two ways: a write together with a fill level one lower, or no write with the fill level unchanged. Some behaviour only the bench scenarios can show, because it needs a model of the queue: which entry is chosen, that the compacted entries keep their order, and that dropped or ignored records never reappear. The bench checks these through a full removal sweep over every slot position and through same-line duplicates.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
   typedef enum logic [1:0] {
      CMD_NONE    = 2'd0,
      CMD_DISCARD = 2'd1,
      CMD_INVAL   = 2'd2,
      CMD_RECORD  = 2'd3
   } lrb_cmd_e;
endpackage

// File: rtl/lrb_store.sv
module lrb_store #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   parameter int IW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   input  logic [IW-1:0] pop_idx,
   input  logic          clear,
   output logic [AW-1:0] addr_q [DEPTH],
   output logic [DW-1:0] data_q [DEPTH],
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (pop) begin
         count <= count - CW'(1);
      end else if (push) begin
         count <= count + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!clear && pop) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (i >= int'(pop_idx)) begin
               addr_q[i] <= addr_q[i+1];
               data_q[i] <= data_q[i+1];
            end
         end
      end else if (!clear && push) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) == count) begin
               addr_q[i] <= push_addr;
               data_q[i] <= push_data;
            end
         end
      end
   end
endmodule

// File: rtl/lrb_match.sv
module lrb_match #(
   parameter int AW        = 32,
   parameter int DEPTH     = 8,
   parameter int LINE_BITS = 5,
   parameter int IW        = $clog2(DEPTH),
   parameter int CW        = $clog2(DEPTH + 1)
) (
   input  logic [AW-1:0] addr_q [DEPTH],
   input  logic [CW-1:0] count,
   input  logic [AW-1:0] key,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [DEPTH-1:0] hit;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = (CW'(g) < count) &&
                      (addr_q[g][AW-1:LINE_BITS] == key[AW-1:LINE_BITS]);
   end

   always_comb begin
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hit[i]) idx = IW'(i);
      end
   end

   assign any = |hit;
endmodule

// File: rtl/lrb_wport.sv
module lrb_wport #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   output logic          wr_valid,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   input  logic          wr_ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else if (load) begin
         wr_valid <= 1'b1;
         wr_addr  <= ld_addr;
         wr_data  <= ld_data;
      end else if (wr_ready) begin
         wr_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/line_replay_buf.sv
module line_replay_buf #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int DEPTH     = 8,
   parameter int LINE_BITS = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rec_valid,
   input  logic [AW-1:0] rec_addr,
   input  logic [DW-1:0] rec_data,
   input  logic          rec_cached,
   input  logic          inv_valid,
   input  logic [AW-1:0] inv_addr,
   input  logic          discard,
   output logic          full,
   output logic          empty,
   output logic          overflow,
   output logic          wr_valid,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   input  logic          wr_ready
);
   import lrb_pkg::*;

   localparam int IW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("line_replay_buf: DEPTH must be at least 2");
   end
   if (LINE_BITS < 1 || LINE_BITS >= AW) begin : g_bad_line
      $error("line_replay_buf: LINE_BITS must lie in 1..AW-1");
   end

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [CW-1:0] count;
   logic          hit_any;
   logic [IW-1:0] hit_idx;
   lrb_cmd_e      cmd;

   always_comb begin
      cmd = CMD_NONE;
      if (!wr_valid) begin
         if (discard)                      cmd = CMD_DISCARD;
         else if (inv_valid)               cmd = CMD_INVAL;
         else if (rec_valid && rec_cached) cmd = CMD_RECORD;
      end
   end

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   wire do_pop  = (cmd == CMD_INVAL) && hit_any;
   wire do_push = (cmd == CMD_RECORD) && !full;
   wire do_ovf  = (cmd == CMD_RECORD) && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overflow <= 1'b0;
      else        overflow <= do_ovf;
   end

   lrb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .IW(IW), .CW(CW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push(do_push), .push_addr(rec_addr), .push_data(rec_data),
      .pop(do_pop), .pop_idx(hit_idx),
      .clear(cmd == CMD_DISCARD),
      .addr_q(addr_q), .data_q(data_q), .count(count)
   );

   lrb_match #(.AW(AW), .DEPTH(DEPTH), .LINE_BITS(LINE_BITS), .IW(IW), .CW(CW)) u_match (
      .addr_q(addr_q), .count(count), .key(inv_addr),
      .any(hit_any), .idx(hit_idx)
   );

   lrb_wport #(.AW(AW), .DW(DW)) u_wport (
      .clk(clk), .rst_n(rst_n),
      .load(do_pop), .ld_addr(addr_q[hit_idx]), .ld_data(data_q[hit_idx]),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_ready(wr_ready)
   );
endmodule

// File: rtl/lrb_chk.sv
module lrb_chk #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rec_valid,
   input logic          rec_cached,
   input logic          inv_valid,
   input logic          discard,
   input logic          full,
   input logic          empty,
   input logic          overflow,
   input logic          wr_valid,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          wr_ready,
   input logic [CW-1:0] count
);
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9
   AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> $stable(count)); // R9
   AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> $past(full) && $past(rec_valid)); // R3
   AST_DISCARD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      discard && !wr_valid |=> empty && !wr_valid); // R8
   AST_UNCACHED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_cached && !inv_valid && !discard && !wr_valid |=> $stable(count)); // R1
   AST_INV_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid && !discard && !wr_valid |=>
         (wr_valid && count == $past(count) - CW'(1)) || (!wr_valid && $stable(count))); // R7
   AST_NOT_FULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R3
endmodule

bind line_replay_buf lrb_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_cached(rec_cached),
   .inv_valid(inv_valid), .discard(discard), .full(full), .empty(empty),
   .overflow(overflow), .wr_valid(wr_valid), .wr_addr(wr_addr),
   .wr_data(wr_data), .wr_ready(wr_ready), .count(count)
);

// File: tb/tb_line_replay_buf.sv
`timescale 1ns/1ps
module tb_line_replay_buf;
   localparam int D = 4;
   logic clk = 0, rst_n = 0;
   logic rec_valid = 0, rec_cached = 0, inv_valid = 0, discard = 0, wr_ready = 0;
   logic [31:0] rec_addr = 0, rec_data = 0, inv_addr = 0;
   logic full, empty, overflow, wr_valid;
   logic [31:0] wr_addr, wr_data;
   int checks = 0, fails = 0;
   bit done = 0;
   logic [31:0] qa[$], qd[$];

   always #5 clk = ~clk;

   line_replay_buf #(.DEPTH(D)) dut (.*);

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_level(string req);
      chk(empty == (qa.size() == 0), req, {31'd0, empty}, {31'd0, qa.size() == 0});
      chk(full == (qa.size() == D), req, {31'd0, full}, {31'd0, qa.size() == D});
   endtask

   task automatic record(logic [31:0] a, logic [31:0] d, bit c);
      bit ovf_exp;
      ovf_exp = c && (qa.size() == D);
      @(negedge clk);
      rec_valid = 1; rec_addr = a; rec_data = d; rec_cached = c;
      @(negedge clk);
      rec_valid = 0;
      if (c && !ovf_exp) begin qa.push_back(a); qd.push_back(d); end
      chk(overflow == ovf_exp, "R3 overflow", {31'd0, overflow}, {31'd0, ovf_exp});
      chk_level(c ? "R3 level" : "R1 level");
   endtask

   task automatic inval(logic [31:0] a, int dly, bit poke);
      int k;
      k = -1;
      foreach (qa[i]) if (k < 0 && qa[i][31:5] == a[31:5]) k = i;
      @(negedge clk);
      inv_valid = 1; inv_addr = a;
      @(negedge clk);
      inv_valid = 0;
      chk(wr_valid == (k >= 0), k >= 0 ? "R5 write" : "R7 nowrite",
          {31'd0, wr_valid}, {31'd0, k >= 0});
      if (k >= 0) begin
         chk(wr_addr == qa[k], "R5 addr", wr_addr, qa[k]);
         chk(wr_data == qd[k], "R5 data", wr_data, qd[k]);
         for (int j = 0; j < dly; j++) begin
            if (poke && j == 0) begin
               rec_valid = 1; rec_cached = 1; rec_addr = 32'h7000; rec_data = 32'hBAD;
               discard = 1;
            end
            @(negedge clk);
            rec_valid = 0; discard = 0;
            chk(wr_valid && wr_addr == qa[k] && wr_data == qd[k], "R9 hold", wr_addr, qa[k]);
         end
         qa.delete(k); qd.delete(k);
         wr_ready = 1;
         @(negedge clk);
         wr_ready = 0;
         chk(!wr_valid, "R9 accepted", {31'd0, wr_valid}, 32'd0);
      end
      chk_level(k >= 0 ? "R6 level" : "R7 level");
   endtask

   task automatic drop_all();
      @(negedge clk);
      discard = 1;
      @(negedge clk);
      discard = 0;
      qa.delete(); qd.delete();
      chk(empty && !full, "R8 empty", {31'd0, empty}, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(empty && !full && !overflow && !wr_valid, "R11 reset",
          {28'd0, empty, full, overflow, wr_valid}, 32'h8);
      rst_n = 1;
      @(negedge clk);

      // R1: uncached store is not kept
      record(32'h0000_0200, 32'h11, 0);
      inval(32'h0000_0204, 0, 0);

      // R4: same line across offsets, neighbour line misses
      record(32'h0000_0100, 32'hA1, 1);
      inval(32'h0000_0120, 0, 0);
      inval(32'h0000_011C, 2, 0);

      // R2/R6: same-line duplicates replay oldest first
      record(32'h0000_0400, 32'hD1, 1);
      record(32'h0000_0900, 32'hE0, 1);
      record(32'h0000_0404, 32'hD2, 1);
      inval(32'h0000_041F, 0, 0);
      inval(32'h0000_0410, 0, 0);
      inval(32'h0000_0900, 0, 0);

      // R3: fill, overflow drop; dropped entry never replays
      for (int i = 0; i < D; i++) record(32'h1000 + 32'(i) * 32'h20, 32'h100 + 32'(i), 1);
      record(32'h0000_3000, 32'hFF, 1);
      inval(32'h0000_3000, 0, 0);
      // R9: commands during pending write ignored
      inval(32'h0000_1020, 3, 1);
      inval(32'h0000_7000, 0, 0);
      drop_all();
      inval(32'h0000_1000, 0, 0);

      // R6 sweep: remove each slot of a full buffer, then drain in order
      for (int k = 0; k < D; k++) begin
         drop_all();
         for (int i = 0; i < D; i++)
            record(32'h2000 + 32'(i) * 32'h40, 32'h5000 + 32'(k * 16 + i), 1);
         inval(32'h2000 + 32'(k) * 32'h40 + 32'h1C, 1, 0);
         while (qa.size() > 0) inval(qa[0] | 32'h3, 0, 0);
      end

      // R10: discard beats record, invalidate beats record
      record(32'h0000_5000, 32'h55, 1);
      @(negedge clk);
      discard = 1; inv_valid = 1; inv_addr = 32'h5000; rec_valid = 1; rec_cached = 1;
      rec_addr = 32'h6000;
      @(negedge clk);
      discard = 0; inv_valid = 0; rec_valid = 0;
      qa.delete(); qd.delete();
      chk(empty && !wr_valid, "R10 discard wins", {30'd0, empty, wr_valid}, 32'h2);
      record(32'h0000_5040, 32'h66, 1);
      @(negedge clk);
      inv_valid = 1; inv_addr = 32'h5040; rec_valid = 1; rec_cached = 1; rec_addr = 32'h6000;
      @(negedge clk);
      inv_valid = 0; rec_valid = 0;
      chk(wr_valid && wr_data == 32'h66, "R10 inval wins", wr_data, 32'h66);
      qa.delete(); qd.delete();
      wr_ready = 1;
      @(negedge clk);
      wr_ready = 0;
      chk_level("R10 record ignored");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule